// File: doc/BRIEF.md
# Bit-Addressed Mixed-Width FIFO

This block is a single-clock FIFO whose storage is a flat ring of 4096 bits. The write side and the read side each move a fixed number of bits per operation, set at elaboration from 1, 2, 4, 8 or 16. The two widths may differ, so a narrow producer can feed a wide consumer or the reverse. Both pointers count bits, not words, and the stored amount is always the distance in bits between them.

Four status outputs are derived from that distance. Full and empty report whether one complete word can still be written or read. Almost-full and almost-empty compare the distance against two 12-bit thresholds given in bits. Two stop controls decide whether a pointer halts at full or empty, or keeps going. If the read side keeps going past empty, the ring is read again from its older contents, which allows a block of data to be played back many times. If the write side keeps going past full, the oldest contents are overwritten.

Top module: `bitwidth_fifo`

## Requirements
- R1: A synchronous active-high reset clears both bit pointers and the read data register. After reset `empty` and `almost_empty` are 1 and `full` is 0.
- R2: An accepted write stores `wr_data` at the write pointer and advances it by WR_W bits. An accepted read loads `rd_data` on the next clock edge with the RD_W bits at the read pointer and advances it by RD_W bits. The bit written first lands in bit 0 of the read word, and `rd_data` holds between accepted reads.
- R3: `empty` is 1 whenever the stored bit count is below RD_W. With 2-bit writes and 4-bit reads, a single write leaves `empty` at 1.
- R4: `full` is 1 whenever the free space is below WR_W bits. With 4-bit writes and 2-bit reads, one read from a full FIFO leaves `full` at 1.
- R5: `almost_full` is 1 exactly when the stored bit count is greater than or equal to `afull_level`.
- R6: `almost_empty` is 1 exactly when the stored bit count is less than or equal to `aempty_level`. A count below zero after a read past empty counts as below the level.
- R7: With `stop_on_full` at 1, a write while `full` is 1 changes neither the storage nor the write pointer.
- R8: With `stop_on_empty` at 1, a read while `empty` is 1 changes neither the read pointer nor `rd_data`.
- R9: With `stop_on_empty` at 0, a read while `empty` is 1 is still performed, so the read pointer moves on through earlier ring contents and returns them again.
- R10: With `stop_on_full` at 0, a write while `full` is 1 is still performed and overwrites the oldest stored bits.
- R11: Both pointers address the ring modulo 4096 bits, so storage and data order remain correct after any number of wraps.
- R12: A read and a write in the same cycle are both carried out. The read returns the contents from before the write, and the flags follow the net change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Registered read word |
| afull_level | input | 12 | Almost-full threshold in bits |
| aempty_level | input | 12 | Almost-empty threshold in bits |
| stop_on_full | input | 1 | 1: writes are ignored while full |
| stop_on_empty | input | 1 | 1: reads are ignored while empty |
| full | output | 1 | Fewer than WR_W free bits |
| empty | output | 1 | Fewer than RD_W stored bits |
| almost_full | output | 1 | Stored bits at or above `afull_level` |
| almost_empty | output | 1 | Stored bits at or below `aempty_level` |

## Verification
The assertions assume that the signed bit distance between the pointers never leaves the range of the 14-bit lap counters. In other words, a write past full never pushes the distance above 8191 bits, and a read past empty never drives it below -8192. With either stop control low, that bound is the caller's responsibility. The stimulus keeps random traffic with both stops high. Overrun and replay are tested only in short directed runs of about 1100 operations, which stay well inside the range for both width pairs.

// File: rtl/bwf_pkg.sv
`timescale 1ns/1ps
package bwf_pkg;

    // status bundle produced by the flag logic
    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
    } bwf_flags_t;

    // per-cycle decision on which requests proceed
    typedef struct packed {
        logic wr_go;
        logic rd_go;
    } bwf_grant_t;

    typedef enum logic [1:0] {
        SIDE_HOLD  = 2'b00,
        SIDE_WRITE = 2'b01,
        SIDE_READ  = 2'b10,
        SIDE_BOTH  = 2'b11
    } bwf_op_e;

    function automatic logic width_ok(int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

    function automatic bwf_op_e op_of(bwf_grant_t g);
        return bwf_op_e'({g.rd_go, g.wr_go});
    endfunction

endpackage

// File: rtl/bwf_ptr.sv
`timescale 1ns/1ps
module bwf_ptr #(
    parameter int unsigned LAP_W = 14,
    parameter int unsigned STEP  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [LAP_W-1:0] lap
);

    localparam logic [LAP_W-1:0] INC = LAP_W'(STEP);

    always_ff @(posedge clk) begin
        if (rst)
            lap <= '0;
        else if (adv)
            lap <= lap + INC;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> lap == $past(lap) + INC) else $error("pointer step"); // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(lap)) else $error("pointer hold"); // R7

endmodule

// File: rtl/bwf_flags.sv
`timescale 1ns/1ps
module bwf_flags
    import bwf_pkg::*;
#(
    parameter int unsigned STORE_BITS = 4096,
    parameter int unsigned LAP_W      = 14,
    parameter int unsigned THR_W      = 12,
    parameter int unsigned WR_W       = 8,
    parameter int unsigned RD_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAP_W-1:0] wlap,
    input  logic [LAP_W-1:0] rlap,
    input  logic [THR_W-1:0] af_lvl,
    input  logic [THR_W-1:0] ae_lvl,
    output bwf_flags_t       flags
);

    localparam logic signed [LAP_W-1:0] FULL_ABOVE = LAP_W'(STORE_BITS - WR_W);
    localparam logic signed [LAP_W-1:0] EMPTY_BELOW = LAP_W'(RD_W);

    logic signed [LAP_W-1:0] fill;
    logic signed [LAP_W-1:0] af_ext;
    logic signed [LAP_W-1:0] ae_ext;

    assign fill   = $signed(wlap - rlap);
    assign af_ext = $signed({{(LAP_W-THR_W){1'b0}}, af_lvl});
    assign ae_ext = $signed({{(LAP_W-THR_W){1'b0}}, ae_lvl});

    always_comb begin
        flags.full   = fill > FULL_ABOVE;
        flags.empty  = fill < EMPTY_BELOW;
        flags.afull  = fill >= af_ext;
        flags.aempty = fill <= ae_ext;
    end

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags.full, flags.empty})) else $error("full and empty together"); // R4
    AST_AE_COVERS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && (32'(ae_lvl) >= RD_W - 1)) |-> flags.aempty) else $error("aempty"); // R6
    AST_AF_COVERS_FULL: assert property (@(posedge clk) disable iff (rst)
        (flags.full && (32'(af_lvl) <= STORE_BITS - WR_W + 1)) |-> flags.afull) else $error("afull"); // R5

endmodule

// File: rtl/bwf_store.sv
`timescale 1ns/1ps
module bwf_store #(
    parameter int unsigned STORE_BITS = 4096,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned WR_W       = 8,
    parameter int unsigned RD_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WR_W-1:0]   wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [RD_W-1:0]   rdata
);

    localparam int unsigned SLOTS = STORE_BITS / WR_W;
    localparam int unsigned WSH   = $clog2(WR_W);
    localparam int unsigned SEL_W = ADDR_W - WSH;

    logic [STORE_BITS-1:0] ring;

    // one register per write slot, selected by the upper address bits
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [WR_W-1:0] q;
        always_ff @(posedge clk) begin
            if (we && waddr[ADDR_W-1:WSH] == SEL_W'(s))
                q <= wdata;
        end
        assign ring[s*WR_W +: WR_W] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= ring[raddr +: RD_W];
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata)) else $error("read data moved"); // R8
    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> ring[$past(waddr) +: WR_W] == $past(wdata)) else $error("write lost"); // R2

endmodule

// File: rtl/bitwidth_fifo.sv
`timescale 1ns/1ps
module bitwidth_fifo
    import bwf_pkg::*;
#(
    parameter int unsigned STORE_BITS = 4096,
    parameter int unsigned WR_W       = 8,
    parameter int unsigned RD_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [WR_W-1:0]               wr_data,
    input  logic                          rd_en,
    output logic [RD_W-1:0]               rd_data,
    input  logic [$clog2(STORE_BITS)-1:0] afull_level,
    input  logic [$clog2(STORE_BITS)-1:0] aempty_level,
    input  logic                          stop_on_full,
    input  logic                          stop_on_empty,
    output logic                          full,
    output logic                          empty,
    output logic                          almost_full,
    output logic                          almost_empty
);

    localparam int unsigned ADDR_W = $clog2(STORE_BITS);
    localparam int unsigned LAP_W  = ADDR_W + 2;

    initial assert (width_ok(WR_W) && width_ok(RD_W)) else $error("unsupported port width");

    logic [LAP_W-1:0] wlap;
    logic [LAP_W-1:0] rlap;
    bwf_flags_t       flags;
    bwf_grant_t       grant;
    bwf_op_e          op;

    always_comb begin
        grant.wr_go = wr_en && !(flags.full && stop_on_full);
        grant.rd_go = rd_en && !(flags.empty && stop_on_empty);
        op          = op_of(grant);
    end

    bwf_ptr #(.LAP_W(LAP_W), .STEP(WR_W)) i_wptr (
        .clk (clk), .rst (rst), .adv (op == SIDE_WRITE || op == SIDE_BOTH), .lap (wlap)
    );

    bwf_ptr #(.LAP_W(LAP_W), .STEP(RD_W)) i_rptr (
        .clk (clk), .rst (rst), .adv (op == SIDE_READ || op == SIDE_BOTH), .lap (rlap)
    );

    bwf_flags #(
        .STORE_BITS (STORE_BITS), .LAP_W (LAP_W), .THR_W (ADDR_W),
        .WR_W (WR_W), .RD_W (RD_W)
    ) i_flags (
        .clk (clk), .rst (rst), .wlap (wlap), .rlap (rlap),
        .af_lvl (afull_level), .ae_lvl (aempty_level), .flags (flags)
    );

    bwf_store #(
        .STORE_BITS (STORE_BITS), .ADDR_W (ADDR_W), .WR_W (WR_W), .RD_W (RD_W)
    ) i_store (
        .clk (clk), .rst (rst),
        .we (grant.wr_go), .waddr (wlap[ADDR_W-1:0]), .wdata (wr_data),
        .re (grant.rd_go), .raddr (rlap[ADDR_W-1:0]), .rdata (rd_data)
    );

    assign full         = flags.full;
    assign empty        = flags.empty;
    assign almost_full  = flags.afull;
    assign almost_empty = flags.aempty;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty && almost_empty && !full && rd_data == '0)) else $error("reset state"); // R1
    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && stop_on_full) |=> $stable(wlap)) else $error("blocked write moved"); // R7
    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && stop_on_empty) |=> $stable(rlap)) else $error("blocked read moved"); // R8
    AST_REPLAY_MOVES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !stop_on_empty) |=> rlap != $past(rlap)) else $error("replay stalled"); // R9
    AST_OVERRUN_MOVES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !stop_on_full) |=> wlap != $past(wlap)) else $error("overrun stalled"); // R10

endmodule

// File: tb/test_bitwidth_fifo.sv
`timescale 1ns/1ps
module test_bitwidth_fifo;

    localparam int NI = 2;
    localparam int RING = 4096;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, wr_en, rd_en, fstop, estop;
    logic [15:0] wdata;
    logic [11:0] afv, aev;
    logic [3:0]  qa;
    logic [1:0]  qb;
    logic        fu [NI];
    logic        em [NI];
    logic        af [NI];
    logic        ae [NI];

    // instance 0: 2-bit writes, 4-bit reads; instance 1: 4-bit writes, 2-bit reads
    bitwidth_fifo #(.WR_W(2), .RD_W(4)) i_bitwidth_fifo (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wdata[1:0]), .rd_en (rd_en),
        .rd_data (qa), .afull_level (afv), .aempty_level (aev),
        .stop_on_full (fstop), .stop_on_empty (estop),
        .full (fu[0]), .empty (em[0]), .almost_full (af[0]), .almost_empty (ae[0])
    );

    bitwidth_fifo #(.WR_W(4), .RD_W(2)) i_bitwidth_fifo_b (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wdata[3:0]), .rd_en (rd_en),
        .rd_data (qb), .afull_level (afv), .aempty_level (aev),
        .stop_on_full (fstop), .stop_on_empty (estop),
        .full (fu[1]), .empty (em[1]), .almost_full (af[1]), .almost_empty (ae[1])
    );

    // reference model
    bit          mb [NI][RING];
    longint      mw [NI];
    longint      mr [NI];
    logic [15:0] mq [NI];
    int          ww [NI] = '{2, 4};
    int          rw [NI] = '{4, 2};

    int n_cmp = 0;
    int n_bad = 0;

    function automatic longint m_fill(int i);
        return mw[i] - mr[i];
    endfunction

    function automatic bit m_full(int i);
        return m_fill(i) > longint'(RING - ww[i]);
    endfunction

    function automatic bit m_empty(int i);
        return m_fill(i) < longint'(rw[i]);
    endfunction

    task automatic cmp(string req, string ph, int i, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) inst%0d %s: actual %0d expected %0d", req, ph, i, what, act, exp);
        end
    endtask

    task automatic check_all(string ph);
        for (int i = 0; i < NI; i++) begin
            logic [15:0] q;
            q = (i == 0) ? {12'b0, qa} : {14'b0, qb};
            cmp("R2", ph, i, "rd_data", q, mq[i]);
            cmp("R4", ph, i, "full", {15'b0, fu[i]}, {15'b0, m_full(i)});
            cmp("R3", ph, i, "empty", {15'b0, em[i]}, {15'b0, m_empty(i)});
            cmp("R5", ph, i, "almost_full", {15'b0, af[i]}, {15'b0, m_fill(i) >= longint'(afv)});
            cmp("R6", ph, i, "almost_empty", {15'b0, ae[i]}, {15'b0, m_fill(i) <= longint'(aev)});
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(string ph, bit we, bit re, logic [15:0] d);
        wr_en = we; rd_en = re; wdata = d;
        for (int i = 0; i < NI; i++) begin
            bit wa, ra;
            wa = we && !(m_full(i) && fstop);
            ra = re && !(m_empty(i) && estop);
            if (ra) begin
                mq[i] = '0;
                for (int b = 0; b < rw[i]; b++) mq[i][b] = mb[i][int'((mr[i] + b) % RING)];
                mr[i] += rw[i];
            end
            if (wa) begin
                for (int b = 0; b < ww[i]; b++) mb[i][int'((mw[i] + b) % RING)] = d[b];
                mw[i] += ww[i];
            end
        end
        @(negedge clk);
        check_all(ph);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rd_en = 0; wdata = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NI; i++) begin mw[i] = 0; mr[i] = 0; mq[i] = '0; end
        check_all("R1 reset");
        for (int i = 0; i < NI; i++) begin
            cmp("R1", "after reset", i, "empty", {15'b0, em[i]}, 16'd1);
            cmp("R1", "after reset", i, "almost_empty", {15'b0, ae[i]}, 16'd1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        fstop = 1; estop = 1; afv = 12'd40; aev = 12'd6;
        wr_en = 0; rd_en = 0; wdata = '0; rst = 1;
        @(negedge clk);
        do_reset();

        // R3: one narrow write does not make a whole wide read word
        step("R3 single write", 1, 0, 16'h3);
        cmp("R3", "single 2-bit write", 0, "empty", {15'b0, em[0]}, 16'd1);
        cmp("R3", "single 4-bit write", 1, "empty", {15'b0, em[1]}, 16'd0);

        // fill the whole ring of both instances, then push extra writes (R7)
        for (int k = 0; k < 2048; k++) step("R11 fill", 1, 0, 16'($urandom));
        cmp("R4", "ring filled", 0, "full", {15'b0, fu[0]}, 16'd1);
        for (int k = 0; k < 20; k++) step("R7 blocked write", 1, 0, 16'hFFFF);

        // R4: one narrow read leaves the wide-write side full
        step("R4 one read", 0, 1, '0);
        cmp("R4", "one 2-bit read", 1, "full", {15'b0, fu[1]}, 16'd1);

        // drain, then extra reads that must be ignored (R8)
        for (int k = 0; k < 2100; k++) step("R2 drain", 0, 1, '0);
        for (int k = 0; k < 20; k++) step("R8 blocked read", 0, 1, '0);
        step("R8 write after blocked reads", 1, 0, 16'hA);
        step("R8 write after blocked reads", 1, 0, 16'h5);
        step("R8 read after blocked reads", 0, 1, '0);
        step("R8 read after blocked reads", 0, 1, '0);

        // random traffic with stops high, including same-cycle read and write (R12)
        for (int blk = 0; blk < 30; blk++) begin
            int wp;
            wp = (blk % 3 == 0) ? 75 : ((blk % 3 == 1) ? 25 : 50);
            afv = 12'($urandom);
            aev = 12'($urandom);
            for (int k = 0; k < 500; k++) begin
                bit we, re;
                if (($urandom % 64) == 0) begin afv = 12'($urandom); aev = 12'($urandom); end
                we = ($urandom % 100) < wp;
                re = ($urandom % 100) < (100 - wp);
                step("R12 random", we, re, 16'($urandom));
            end
        end

        // R9: replay past empty
        do_reset();
        estop = 0; afv = 12'd100; aev = 12'd3;
        for (int k = 0; k < 8; k++) step("R9 seed", 1, 0, 16'($urandom));
        for (int k = 0; k < 1100; k++) step("R9 replay", 0, 1, '0);
        estop = 1;

        // R10: overwrite past full
        do_reset();
        fstop = 0;
        for (int k = 0; k < 1100; k++) step("R10 overrun", 1, 0, 16'($urandom));
        fstop = 1;
        for (int k = 0; k < 600; k++) step("R10 read back", 0, 1, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule